// File: doc/BRIEF.md
# DMA Address Translation Unit

This block turns addresses issued by DMA-capable devices into physical memory addresses by consulting a single-level table held in memory. The table is an array of 8-byte entries. A base register gives its location, and a control register sets its size and its indexing granule. For each lookup the block computes the entry address from a slice of the DMA address and issues one read on its memory-request port. It then decodes the returned entry and answers with the physical address, page mask, page-aligned DMA address and a permission code.

Software reaches the two 64-bit registers over a simple register port. It can access either 32-bit half or the whole register at once. Only one lookup is in flight at a time. Lookups arrive through a valid/ready request, and results leave through a valid/ready response that holds steady until it is taken. Translation results are not cached, so a write to the flush location has no effect.

Top module: `dma_xlate`

## Requirements
- R1: After reset the control and base registers read zero, `req_ready` is high, and `mem_valid` and `rsp_valid` are low.
- R2: The control register sits at offset 0x0 and the base register at 0x8. A 64-bit access (`reg_wide`=1) at either offset reaches the whole register. A 32-bit access at that offset reaches bits 63:32, returned or taken on data bits 31:0. Any access at offset +4 reaches bits 31:0.
- R3: Offsets 0x10 and 0x14 (flush), and every offset other than 0x0, 0x4, 0x8, 0x0C, 0x10 and 0x14, read as zero. Writes to them change no register.
- R4: With control bit 0 clear, a lookup issues no memory read. It answers with permission 2'b11 (read/write), `rsp_pa` equal to the DMA address, `rsp_mask` 0x1FFF and `rsp_iova` equal to the address with bits 12:0 cleared.
- R5: With control bit 0 set and control bit 2 clear, the entry is read at base + 8 × ((addr >> 13) mod 2^(10+code)), where code is control bits 18:16 (0–7).
- R6: With control bits 0 and 2 set and code 0–5, the entry is read at base + 8 × ((addr >> 16) mod 2^(10+code)). With code 6 or 7, no memory read is issued and the answer carries permission 2'b00.
- R7: A returned entry with bit 63 clear gives permission 2'b00, `rsp_pa` 0, `rsp_iova` 0 and `rsp_mask` of all ones. Every no-permission answer has this form.
- R8: For a valid entry, bit 1 set gives permission 2'b11 and bit 1 clear gives 2'b01 (read-only). Permission 2'b10 never appears.
- R9: For a valid entry with bit 61 set, `rsp_mask` is 0xFFFF and the page base is entry & 0x1FFFFFF8000. With bit 61 clear, the mask is 0x1FFF and the base is entry & 0x1FFFFFFE000. `rsp_pa` is base OR (addr AND mask), and `rsp_iova` is addr AND NOT mask.
- R10: From acceptance of a request until its response is taken, `req_ready` is low. A stalled `mem_valid` keeps `mem_addr` stable, and a stalled `rsp_valid` keeps all response fields stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_en | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, combinational while reg_en is high |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Block can accept a lookup |
| req_addr | input | DA_W | DMA address to translate |
| mem_valid | output | 1 | Table entry read request |
| mem_ready | input | 1 | Memory accepts the read |
| mem_addr | output | 64 | Byte address of the entry |
| mem_rvalid | input | 1 | Entry data returned |
| mem_rdata | input | 64 | Entry, byte at lowest address in bits 63:56 |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_perm | output | 2 | 00 none, 01 read-only, 11 read/write |
| rsp_pa | output | 64 | Translated physical address |
| rsp_mask | output | 64 | In-page offset mask |
| rsp_iova | output | DA_W | Page-aligned DMA address |

## Verification
A wrong index slice or wrong granule selection shows on `mem_addr` in the cycle the read is issued. This is the cycle after the request is accepted, before any data returns. A wrong entry decode shows in the response one cycle after `mem_rvalid`, in the permission, mask or combined address. Register half-selection errors show on the very next read of the opposite half or of the whole register. A sequencing fault that lets a second lookup in, or that drops a held response, shows as `req_ready` rising early or as response fields changing while `rsp_ready` is low.

// File: rtl/dma_xlate.sv
module dma_xlate #(
  parameter int DA_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_en,
  input  logic            reg_wr,
  input  logic            reg_wide,
  input  logic [4:0]      reg_addr,
  input  logic [63:0]     reg_wdata,
  output logic [63:0]     reg_rdata,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [DA_W-1:0] req_addr,
  output logic            mem_valid,
  input  logic            mem_ready,
  output logic [63:0]     mem_addr,
  input  logic            mem_rvalid,
  input  logic [63:0]     mem_rdata,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [1:0]      rsp_perm,
  output logic [63:0]     rsp_pa,
  output logic [63:0]     rsp_mask,
  output logic [DA_W-1:0] rsp_iova
);
  localparam logic [63:0] MASK8K  = 64'h1FFF;
  localparam logic [63:0] MASK64K = 64'hFFFF;
  localparam logic [63:0] PHYS8K  = 64'h1FF_FFFF_E000;
  localparam logic [63:0] PHYS64K = 64'h1FF_FFFF_8000;

  typedef enum logic [1:0] {S_IDLE, S_MEM, S_WAIT, S_RSP} state_t;
  state_t state;

  logic [63:0] ctrl, base;
  logic [DA_W-1:0] q_addr;

  wire        en     = ctrl[0];
  wire        big    = ctrl[2];
  wire [2:0]  code   = ctrl[18:16];
  wire        bad_sz = big && (code > 3'd5);

  wire [DA_W-1:0] slice   = big ? (req_addr >> 16) : (req_addr >> 13);
  wire [DA_W-1:0] idx_msk = DA_W'((64'd1 << (10 + code)) - 64'd1);
  wire [63:0]     offset  = 64'(slice & idx_msk) << 3;

  wire [63:0] a64    = 64'(q_addr);
  wire        e_big  = mem_rdata[61];
  wire [63:0] e_mask = e_big ? MASK64K : MASK8K;
  wire [63:0] e_phys = mem_rdata & (e_big ? PHYS64K : PHYS8K);

  wire       is_hi  = !reg_addr[2] && (reg_addr[1:0] == 2'b00);
  wire       is_lo  =  reg_addr[2] && (reg_addr[1:0] == 2'b00);
  wire       hit_c  = reg_addr[4:3] == 2'd0;
  wire       hit_b  = reg_addr[4:3] == 2'd1;
  wire       do_wr  = reg_en && reg_wr;

  function automatic logic [63:0] upd(input logic [63:0] cur);
    if (is_hi && reg_wide)  return reg_wdata;
    else if (is_hi)         return {reg_wdata[31:0], cur[31:0]};
    else if (is_lo)         return {cur[63:32], reg_wdata[31:0]};
    else                    return cur;
  endfunction

  function automatic logic [63:0] rd(input logic [63:0] cur);
    if (is_hi && reg_wide)  return cur;
    else if (is_hi)         return {32'd0, cur[63:32]};
    else if (is_lo)         return {32'd0, cur[31:0]};
    else                    return 64'd0;
  endfunction

  always_comb begin
    reg_rdata = 64'd0;
    if (reg_en && !reg_wr) begin
      if (hit_c)      reg_rdata = rd(ctrl);
      else if (hit_b) reg_rdata = rd(base);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= 64'd0;
      base <= 64'd0;
    end else if (do_wr) begin
      if (hit_c) ctrl <= upd(ctrl);
      if (hit_b) base <= upd(base);
    end
  end

  assign req_ready = state == S_IDLE;
  assign mem_valid = state == S_MEM;
  assign rsp_valid = state == S_RSP;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      q_addr   <= '0;
      mem_addr <= 64'd0;
      rsp_perm <= 2'b00;
      rsp_pa   <= 64'd0;
      rsp_mask <= '1;
      rsp_iova <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          q_addr   <= req_addr;
          mem_addr <= base + offset;
          if (!en) begin
            rsp_perm <= 2'b11;
            rsp_pa   <= 64'(req_addr);
            rsp_mask <= MASK8K;
            rsp_iova <= req_addr & ~DA_W'(MASK8K);
            state    <= S_RSP;
          end else if (bad_sz) begin
            rsp_perm <= 2'b00;
            rsp_pa   <= 64'd0;
            rsp_mask <= '1;
            rsp_iova <= '0;
            state    <= S_RSP;
          end else begin
            state <= S_MEM;
          end
        end
        S_MEM: if (mem_ready) state <= S_WAIT;
        S_WAIT: if (mem_rvalid) begin
          if (!mem_rdata[63]) begin
            rsp_perm <= 2'b00;
            rsp_pa   <= 64'd0;
            rsp_mask <= '1;
            rsp_iova <= '0;
          end else begin
            rsp_perm <= mem_rdata[1] ? 2'b11 : 2'b01;
            rsp_pa   <= e_phys | (a64 & e_mask);
            rsp_mask <= e_mask;
            rsp_iova <= q_addr & ~DA_W'(e_mask);
          end
          state <= S_RSP;
        end
        S_RSP: if (rsp_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_xlate_chk.sv
module dma_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        mem_valid,
  input logic        mem_ready,
  input logic [63:0] mem_addr,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [1:0]  rsp_perm,
  input logic [63:0] rsp_pa,
  input logic [63:0] rsp_mask
);
  // R10
  one_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_ready, mem_valid, rsp_valid}));

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pa) && $stable(rsp_mask) && $stable(rsp_perm)));

  // R8
  perm_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_perm != 2'b10));

  // R7
  no_perm_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_perm == 2'b00) |-> (rsp_pa == 64'd0 && rsp_mask == '1));

  // R10
  ready_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready) |=> req_ready);
endmodule

bind dma_xlate dma_xlate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .mem_valid(mem_valid),
  .mem_ready(mem_ready), .mem_addr(mem_addr), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_perm(rsp_perm), .rsp_pa(rsp_pa), .rsp_mask(rsp_mask)
);

// File: tb/dma_xlate_test.sv
`timescale 1ns/1ps
module dma_xlate_test;
  localparam int DA_W = 32;

  logic clk = 0, rst_n = 0;
  logic reg_en = 0, reg_wr = 0, reg_wide = 0;
  logic [4:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0, reg_rdata;
  logic req_valid = 0, req_ready;
  logic [DA_W-1:0] req_addr = '0;
  logic mem_valid, mem_ready = 1;
  logic [63:0] mem_addr;
  logic mem_rvalid = 0;
  logic [63:0] mem_rdata = '0;
  logic rsp_valid, rsp_ready = 1;
  logic [1:0] rsp_perm;
  logic [63:0] rsp_pa, rsp_mask;
  logic [DA_W-1:0] rsp_iova;

  int tests = 0, fails = 0, nreads = 0;
  logic [63:0] seen_addr = '0, entry = '0;
  logic [1:0] g_perm;
  logic [63:0] g_pa, g_mask;
  logic [DA_W-1:0] g_iova;
  bit done = 0;

  always #2 clk = ~clk;

  dma_xlate #(.DA_W(DA_W)) uut (.*);

  task automatic chk(input string r, input string what, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", r, what, act, exp);
    end
  endtask

  initial forever begin
    @(negedge clk);
    if (mem_valid) begin
      seen_addr = mem_addr;
      nreads++;
      @(negedge clk);
      mem_rdata = entry;
      mem_rvalid = 1;
      @(negedge clk);
      mem_rvalid = 0;
    end
  end

  task automatic wreg(input logic [4:0] a, input logic w, input logic [63:0] d);
    @(negedge clk);
    reg_en = 1; reg_wr = 1; reg_wide = w; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 0; reg_wr = 0;
  endtask

  task automatic rreg(input logic [4:0] a, input logic w, output logic [63:0] d);
    @(negedge clk);
    reg_en = 1; reg_wr = 0; reg_wide = w; reg_addr = a;
    #1 d = reg_rdata;
    reg_en = 0;
  endtask

  task automatic lookup(input logic [DA_W-1:0] a);
    int n;
    @(negedge clk);
    req_valid = 1; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    n = 0;
    while (!rsp_valid && n < 40) begin @(negedge clk); n++; end
    g_perm = rsp_perm; g_pa = rsp_pa; g_mask = rsp_mask; g_iova = rsp_iova;
    if (rsp_ready) @(negedge clk);
  endtask

  function automatic logic [63:0] idx_addr(input logic [63:0] b, input logic [DA_W-1:0] a, input int sh, input int code);
    logic [63:0] s = 64'(a) >> sh;
    return b + ((s & ((64'd1 << (10 + code)) - 1)) << 3);
  endfunction

  task automatic t_reset;
    logic [63:0] d;
    chk("R1", "req_ready", 64'(req_ready), 1);
    chk("R1", "mem_valid", 64'(mem_valid), 0);
    chk("R1", "rsp_valid", 64'(rsp_valid), 0);
    rreg(5'h00, 1, d); chk("R1", "ctrl", d, 0);
    rreg(5'h08, 1, d); chk("R1", "base", d, 0);
  endtask

  task automatic t_regs;
    logic [63:0] d;
    wreg(5'h08, 1, 64'h1122334455667700);
    rreg(5'h08, 0, d); chk("R2", "base upper half", d, 64'h11223344);
    rreg(5'h0C, 0, d); chk("R2", "base lower half", d, 64'h55667700);
    wreg(5'h08, 0, 64'hAABBCCDD);
    rreg(5'h08, 1, d); chk("R2", "narrow upper write", d, 64'hAABBCCDD55667700);
    wreg(5'h0C, 0, 64'h00001000);
    rreg(5'h08, 1, d); chk("R2", "lower write", d, 64'hAABBCCDD00001000);
    wreg(5'h04, 0, 64'h00050000);
    rreg(5'h00, 1, d); chk("R2", "ctrl lower write", d, 64'h00050000);
    wreg(5'h00, 1, 64'h0);
  endtask

  task automatic t_ignored;
    logic [63:0] d;
    wreg(5'h10, 1, 64'hFFFFFFFFFFFFFFFF);
    wreg(5'h14, 0, 64'hFFFFFFFF);
    wreg(5'h18, 1, 64'hFFFFFFFFFFFFFFFF);
    rreg(5'h10, 1, d); chk("R3", "flush read", d, 0);
    rreg(5'h18, 1, d); chk("R3", "unknown read", d, 0);
    rreg(5'h08, 1, d); chk("R3", "base untouched", d, 64'hAABBCCDD00001000);
    rreg(5'h00, 1, d); chk("R3", "ctrl untouched", d, 0);
  endtask

  task automatic t_pass;
    int r0 = nreads;
    lookup(32'h12345678);
    chk("R4", "perm", 64'(g_perm), 2'b11);
    chk("R4", "pa", g_pa, 64'h12345678);
    chk("R4", "mask", g_mask, 64'h1FFF);
    chk("R4", "iova", 64'(g_iova), 64'h12344000);
    chk("R4", "no memory read", 64'(nreads - r0), 0);
  endtask

  task automatic t_8k;
    logic [DA_W-1:0] a = 32'h0ABCD123;
    wreg(5'h08, 1, 64'h40000000);
    wreg(5'h00, 1, 64'h00030001);
    entry = (64'd1 << 63) | (64'h1ABCDE << 13) | 64'h2;
    lookup(a);
    chk("R5", "entry addr code3", seen_addr, idx_addr(64'h40000000, a, 13, 3));
    chk("R9", "pa 8K", g_pa, (entry & 64'h1FFFFFFE000) | (64'(a) & 64'h1FFF));
    chk("R9", "mask 8K", g_mask, 64'h1FFF);
    chk("R9", "iova 8K", 64'(g_iova), 64'(a) & ~64'h1FFF);
    chk("R8", "rw perm", 64'(g_perm), 2'b11);
    wreg(5'h00, 1, 64'h00000001);
    lookup(32'hFFFFFFFF);
    chk("R5", "entry addr code0", seen_addr, 64'h40000000 + (64'h3FF << 3));
    wreg(5'h00, 1, 64'h00070001);
    lookup(32'hFFFFFFFF);
    chk("R5", "entry addr code7", seen_addr, idx_addr(64'h40000000, 32'hFFFFFFFF, 13, 7));
  endtask

  task automatic t_64k;
    logic [DA_W-1:0] a = 32'h7654321A;
    int r0;
    wreg(5'h00, 1, 64'h00050005);
    entry = (64'd1 << 63) | (64'd1 << 61) | (64'h123 << 16) | (64'd1 << 15);
    lookup(a);
    chk("R6", "entry addr code5", seen_addr, idx_addr(64'h40000000, a, 16, 5));
    chk("R8", "ro perm", 64'(g_perm), 2'b01);
    chk("R9", "mask 64K", g_mask, 64'hFFFF);
    chk("R9", "pa 64K", g_pa, (entry & 64'h1FFFFFF8000) | (64'(a) & 64'hFFFF));
    chk("R9", "iova 64K", 64'(g_iova), 64'(a) & ~64'hFFFF);
    wreg(5'h00, 1, 64'h00000005);
    lookup(a);
    chk("R6", "entry addr code0", seen_addr, idx_addr(64'h40000000, a, 16, 0));
    r0 = nreads;
    wreg(5'h00, 1, 64'h00060005);
    lookup(a);
    chk("R6", "code6 perm", 64'(g_perm), 0);
    chk("R6", "code6 no read", 64'(nreads - r0), 0);
    chk("R7", "code6 mask", g_mask, 64'hFFFFFFFFFFFFFFFF);
  endtask

  task automatic t_invalid;
    wreg(5'h00, 1, 64'h00020001);
    entry = (64'd1 << 61) | 64'h2 | (64'h55 << 13);
    lookup(32'h00123456);
    chk("R7", "perm", 64'(g_perm), 0);
    chk("R7", "pa", g_pa, 0);
    chk("R7", "iova", 64'(g_iova), 0);
    chk("R7", "mask", g_mask, 64'hFFFFFFFFFFFFFFFF);
  endtask

  task automatic t_stall;
    logic [63:0] pa0;
    entry = (64'd1 << 63) | (64'h77 << 13);
    rsp_ready = 0;
    lookup(32'h00004321);
    pa0 = g_pa;
    chk("R10", "busy req_ready", 64'(req_ready), 0);
    repeat (3) @(negedge clk);
    chk("R10", "held valid", 64'(rsp_valid), 1);
    chk("R10", "held pa", rsp_pa, pa0);
    chk("R10", "pa value", pa0, (64'h77 << 13) | 64'h0321);
    rsp_ready = 1;
    @(negedge clk);
    chk("R10", "taken", 64'(rsp_valid), 0);
    chk("R10", "ready again", 64'(req_ready), 1);
  endtask

  initial begin
    #40000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_ignored();
    t_pass();
    t_8k();
    t_64k();
    t_invalid();
    t_stall();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule